// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-page to physical-page mappings and answers lookups from them. A lookup supplies a virtual page number and an access type. If a valid entry matches, the block returns either the physical page number or a protection fault in the cycle after the request is accepted. If no entry matches, it asks an external page-table walker for the mapping, installs the answer and runs the lookup again. A walker answer that reports an absent or swapped-out page produces a page fault, and nothing is installed.

Each entry holds a valid flag, read, write and execute permissions, a dirty flag, the virtual page tag and the physical page number. The search covers every entry at once. A refill goes into the least recently used slot, which is tracked with one age counter per entry. A write to the page-table base register clears the whole buffer. An invalidate command removes the one entry that matches a given virtual page. If either command arrives while a walk is in flight, the walk's answer is thrown away and the walk is issued again, so a stale mapping can never be installed. Only one lookup is in progress at a time.

Top module: `fa_tlb`

## Requirements
- R1: After reset, no entry is valid, `req_ready_o` is 1, and both `resp_valid_o` and `walk_req_o` are 0.
- R2: An accepted lookup that matches a valid entry with the needed permission gives `resp_valid_o` for one cycle, in the cycle after acceptance. It reports kind OK (0) and that entry's physical page, and it issues no walk.
- R3: A lookup that misses holds `walk_req_o` high with `walk_vpn_o` stable until the walker answers. A valid answer is installed, the lookup is retried and responds OK, and later lookups of that page hit without a walk.
- R4: A walker answer with `walk_rsp_ok_i` at 0 gives kind PAGE_FAULT (2) with physical page 0 and installs nothing, so the same page walks again on its next lookup.
- R5: Access type encoding: read=0, write=1, exec=2. Permission bits are bit 2 read, bit 1 write and bit 0 exec. An access the matching entry does not permit gives kind PROT (1) with physical page 0.
- R6: `resp_dirty_o` reports the entry's dirty flag as it was before the access. A permitted write sets that flag, so a second write to the same page reports 1.
- R7: A cycle with `ptbr_we_i` high invalidates every entry, so every page walks again on its next lookup.
- R8: `inval_valid_i` clears only the entry whose tag equals `inval_vpn_i`. Other entries keep hitting.
- R9: A flush or invalidate that arrives while a walk is outstanding causes that walk's answer to be discarded. The lookup then walks again before it responds.
- R10: A refill replaces the least recently used entry. Hits and refills make an entry the most recent. An invalidated entry becomes the next victim.
- R11: `req_ready_o` is 0 while a lookup is in progress and during any cycle with a flush or invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Lookup can be accepted |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_acc_i | input | 2 | Access type (0 read, 1 write, 2 exec) |
| resp_valid_o | output | 1 | Response strobe |
| resp_kind_o | output | 2 | 0 OK, 1 protection fault, 2 page fault |
| resp_ppn_o | output | PPN_W | Physical page number (0 on a fault) |
| resp_dirty_o | output | 1 | Entry dirty flag before this access |
| walk_req_o | output | 1 | Walk request, held until answered |
| walk_vpn_o | output | VPN_W | Page to walk |
| walk_rsp_valid_i | input | 1 | Walker answer strobe |
| walk_rsp_ok_i | input | 1 | Mapping present |
| walk_rsp_ppn_i | input | PPN_W | Returned physical page |
| walk_rsp_perm_i | input | 3 | Returned permissions {r,w,x} |
| walk_rsp_dirty_i | input | 1 | Returned dirty flag |
| ptbr_we_i | input | 1 | Page-table base write: flush all |
| inval_valid_i | input | 1 | Single-page invalidate |
| inval_vpn_i | input | VPN_W | Page to invalidate |

## Verification
Lookups are applied as first-touch misses, repeated hits, permission-denied accesses of each type and walker page faults. Counting walks between responses separates a hit from a refill. A page that faulted once and then faults again shows whether a failed walk installed anything. Flushes and invalidates are issued both while the block is idle and in the middle of a walk, which separates correct discarding from the installation of a stale answer. The whole buffer is filled, selected entries are touched, and then new pages are forced in. The bench probes which old pages still hit to confirm the recency order and the reuse of invalidated slots.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_PROT = 2'd1, RES_PGFLT = 2'd2} res_e;
  localparam int unsigned PERM_R = 2;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 0;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  output logic [2:0]       lk_perm_o,
  output logic             lk_dirty_o,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  output logic             inv_hit_o,
  output logic [IDX_W-1:0] inv_idx_o,
  input  logic             flush_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [2:0]       fill_perm_i,
  input  logic             fill_dirty_i,
  input  logic             set_dirty_i,
  input  logic [IDX_W-1:0] set_idx_i
);
  logic [ENTRIES-1:0] valid_q, dirty_q, lk_match, inv_match;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]  = valid_q[g] && (vpn_q[g] == lk_vpn_i);
    assign inv_match[g] = valid_q[g] && (vpn_q[g] == inv_vpn_i);
  end

  always_comb begin
    lk_idx_o  = '0;
    inv_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i])  lk_idx_o  = IDX_W'(i);
      if (inv_match[i]) inv_idx_o = IDX_W'(i);
    end
  end

  assign lk_hit_o   = |lk_match;
  assign inv_hit_o  = |inv_match;
  assign lk_ppn_o   = ppn_q[lk_idx_o];
  assign lk_perm_o  = perm_q[lk_idx_o];
  assign lk_dirty_o = dirty_q[lk_idx_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      if (fill_i) begin
        valid_q[fill_idx_i] <= 1'b1;
        dirty_q[fill_idx_i] <= fill_dirty_i;
      end
      if (set_dirty_i) dirty_q[set_idx_i] <= 1'b1;
      if (inv_i && inv_hit_o) valid_q[inv_idx_o] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      vpn_q[fill_idx_i]  <= fill_vpn_i;
      ppn_q[fill_idx_i]  <= fill_ppn_i;
      perm_q[fill_idx_i] <= fill_perm_i;
    end
  end

  a_r7_flush_clears_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  a_r8_inval_one_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && !flush_i && !fill_i) |=> ($countones(valid_q) + 1 >= $countones($past(valid_q))));
  a_r8_inval_target_gone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && inv_hit_o && !fill_i) |=> !inv_hit_o || ($past(inv_vpn_i) != inv_vpn_i));
endmodule

// File: rtl/tlb_age_lru.sv
module tlb_age_lru #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             demote_i,
  input  logic [IDX_W-1:0] demote_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touch_age, demote_age;

  assign touch_age  = age_q[touch_idx_i];
  assign demote_age = age_q[demote_idx_i];

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == AGE_MAX) victim_o = IDX_W'(i);
  end

  // ages stay a permutation of 0..ENTRIES-1; largest is the victim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (flush_i) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (demote_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == demote_idx_i)  age_q[i] <= AGE_MAX;
        else if (age_q[i] > demote_age) age_q[i] <= age_q[i] - 1'b1;
      end
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx_i)  age_q[i] <= '0;
        else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  a_r10_touched_youngest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && !demote_i && !flush_i) |=> (age_q[$past(touch_idx_i)] == '0));
  a_r10_victim_is_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q[victim_o] == AGE_MAX);
  a_r10_demoted_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (demote_i && !flush_i) |=> (victim_o == $past(demote_idx_i)));
endmodule

// File: rtl/tlb_walk_ctrl.sv
module tlb_walk_ctrl
  import fa_tlb_pkg::*;
#(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [1:0]       req_acc_i,
  input  logic             flush_i,
  input  logic             inv_i,
  output logic [VPN_W-1:0] lk_vpn_o,
  input  logic             lk_hit_i,
  input  logic [PPN_W-1:0] lk_ppn_i,
  input  logic [2:0]       lk_perm_i,
  input  logic             lk_dirty_i,
  output logic             touch_o,
  output logic             set_dirty_o,
  output logic             fill_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  input  logic             walk_rsp_valid_i,
  input  logic             walk_rsp_ok_i,
  output logic             resp_valid_o,
  output logic [1:0]       resp_kind_o,
  output logic [PPN_W-1:0] resp_ppn_o,
  output logic             resp_dirty_o
);
  typedef enum logic [1:0] {S_IDLE, S_WALK, S_RETRY} st_e;

  st_e st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic [1:0]       acc_q, lk_acc;
  logic             abort_q;
  logic accept, lk_en, perm_ok, rsp_take, discard, pgflt;

  assign req_ready_o = (st_q == S_IDLE) && !flush_i && !inv_i;
  assign accept      = req_valid_i && req_ready_o;
  assign lk_en       = accept || (st_q == S_RETRY);
  assign lk_vpn_o    = (st_q == S_IDLE) ? req_vpn_i : vpn_q;
  assign lk_acc      = (st_q == S_IDLE) ? req_acc_i : acc_q;

  always_comb begin
    unique case (lk_acc)
      ACC_READ:  perm_ok = lk_perm_i[PERM_R];
      ACC_WRITE: perm_ok = lk_perm_i[PERM_W];
      ACC_EXEC:  perm_ok = lk_perm_i[PERM_X];
      default:   perm_ok = 1'b0;
    endcase
  end

  assign touch_o     = lk_en && lk_hit_i;
  assign set_dirty_o = touch_o && perm_ok && (lk_acc == ACC_WRITE) && !lk_dirty_i;
  assign rsp_take    = (st_q == S_WALK) && walk_rsp_valid_i;
  assign discard     = rsp_take && (abort_q || flush_i || inv_i);
  assign fill_o      = rsp_take && !discard && walk_rsp_ok_i;
  assign pgflt       = rsp_take && !discard && !walk_rsp_ok_i;
  assign walk_req_o  = (st_q == S_WALK);
  assign walk_vpn_o  = vpn_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (accept && !lk_hit_i) st_d = S_WALK;
      S_RETRY: st_d = lk_hit_i ? S_IDLE : S_WALK;
      S_WALK:  if (rsp_take) st_d = pgflt ? S_IDLE : S_RETRY;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      vpn_q        <= '0;
      acc_q        <= '0;
      abort_q      <= 1'b0;
      resp_valid_o <= 1'b0;
      resp_kind_o  <= RES_OK;
      resp_ppn_o   <= '0;
      resp_dirty_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        vpn_q <= req_vpn_i;
        acc_q <= req_acc_i;
      end
      if (rsp_take)                                abort_q <= 1'b0;
      else if (st_q == S_WALK && (flush_i || inv_i)) abort_q <= 1'b1;
      resp_valid_o <= touch_o || pgflt;
      resp_kind_o  <= pgflt ? RES_PGFLT : (perm_ok ? RES_OK : RES_PROT);
      resp_ppn_o   <= (touch_o && perm_ok) ? lk_ppn_i : '0;
      resp_dirty_o <= touch_o ? lk_dirty_i : 1'b0;
    end
  end

  a_r3_walk_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && !walk_rsp_valid_i) |=> (walk_req_o && $stable(walk_vpn_o)));
  a_r5_fault_no_ppn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_kind_o != RES_OK) |-> (resp_ppn_o == '0));
  a_r11_walk_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o |-> !req_ready_o);
  a_r2_resp_ends_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !walk_req_o);
  a_r9_no_stale_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_WALK) && (flush_i || inv_i) && !walk_rsp_valid_i) |=> !fill_o);
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [1:0]       req_acc_i,
  output logic             resp_valid_o,
  output logic [1:0]       resp_kind_o,
  output logic [PPN_W-1:0] resp_ppn_o,
  output logic             resp_dirty_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  input  logic             walk_rsp_valid_i,
  input  logic             walk_rsp_ok_i,
  input  logic [PPN_W-1:0] walk_rsp_ppn_i,
  input  logic [2:0]       walk_rsp_perm_i,
  input  logic             walk_rsp_dirty_i,
  input  logic             ptbr_we_i,
  input  logic             inval_valid_i,
  input  logic [VPN_W-1:0] inval_vpn_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0] lk_vpn;
  logic             lk_hit, lk_dirty, inv_hit;
  logic [IDX_W-1:0] lk_idx, inv_idx, victim, touch_idx;
  logic [PPN_W-1:0] lk_ppn;
  logic [2:0]       lk_perm;
  logic             touch, set_dirty, fill;

  assign touch_idx = fill ? victim : lk_idx;

  tlb_walk_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_vpn_i, .req_acc_i,
    .flush_i      (ptbr_we_i),
    .inv_i        (inval_valid_i),
    .lk_vpn_o     (lk_vpn),
    .lk_hit_i     (lk_hit),
    .lk_ppn_i     (lk_ppn),
    .lk_perm_i    (lk_perm),
    .lk_dirty_i   (lk_dirty),
    .touch_o      (touch),
    .set_dirty_o  (set_dirty),
    .fill_o       (fill),
    .walk_req_o, .walk_vpn_o, .walk_rsp_valid_i, .walk_rsp_ok_i,
    .resp_valid_o, .resp_kind_o, .resp_ppn_o, .resp_dirty_o
  );

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
    .clk_i, .rst_ni,
    .lk_vpn_i     (lk_vpn),
    .lk_hit_o     (lk_hit),
    .lk_idx_o     (lk_idx),
    .lk_ppn_o     (lk_ppn),
    .lk_perm_o    (lk_perm),
    .lk_dirty_o   (lk_dirty),
    .inv_i        (inval_valid_i),
    .inv_vpn_i    (inval_vpn_i),
    .inv_hit_o    (inv_hit),
    .inv_idx_o    (inv_idx),
    .flush_i      (ptbr_we_i),
    .fill_i       (fill),
    .fill_idx_i   (victim),
    .fill_vpn_i   (walk_vpn_o),
    .fill_ppn_i   (walk_rsp_ppn_i),
    .fill_perm_i  (walk_rsp_perm_i),
    .fill_dirty_i (walk_rsp_dirty_i),
    .set_dirty_i  (set_dirty),
    .set_idx_i    (lk_idx)
  );

  tlb_age_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk_i, .rst_ni,
    .flush_i      (ptbr_we_i),
    .touch_i      (touch || fill),
    .touch_idx_i  (touch_idx),
    .demote_i     (inval_valid_i && inv_hit),
    .demote_idx_i (inv_idx),
    .victim_o     (victim)
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!resp_valid_o && !walk_req_o));
endmodule

// File: tb/tb_fa_tlb.sv
`timescale 1ns/1ps
module tb_fa_tlb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam logic [19:0] XKEY = 20'hABCDE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, resp_valid, resp_dirty, walk_req;
  logic [VPN_W-1:0] req_vpn = '0, walk_vpn, inval_vpn = '0;
  logic [1:0] req_acc = '0, resp_kind;
  logic [PPN_W-1:0] resp_ppn, rsp_ppn = '0;
  logic rsp_valid = 0, rsp_ok = 0, rsp_dirty = 0, ptbr_we = 0, inval_valid = 0;
  logic [2:0] rsp_perm = '0;

  always #4 clk = ~clk;

  fa_tlb dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vpn_i(req_vpn), .req_acc_i(req_acc),
    .resp_valid_o(resp_valid), .resp_kind_o(resp_kind), .resp_ppn_o(resp_ppn), .resp_dirty_o(resp_dirty),
    .walk_req_o(walk_req), .walk_vpn_o(walk_vpn),
    .walk_rsp_valid_i(rsp_valid), .walk_rsp_ok_i(rsp_ok), .walk_rsp_ppn_i(rsp_ppn),
    .walk_rsp_perm_i(rsp_perm), .walk_rsp_dirty_i(rsp_dirty),
    .ptbr_we_i(ptbr_we), .inval_valid_i(inval_valid), .inval_vpn_i(inval_vpn)
  );

  typedef struct {
    logic [1:0]       kind;
    logic [PPN_W-1:0] ppn;
    logic             dirty;
    int               walks;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, walk_cnt = 0, walk_base = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string act, input string expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s, expected %s", tag, act, expv);
    end
  endtask

  // walker model: bit12 set = absent page; bits 8/9/10 set deny r/w/x; bit11 = dirty
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && walk_req) begin
        logic [19:0] v;
        v = walk_vpn;
        repeat (3) @(negedge clk);
        rsp_valid = 1; rsp_ok = !v[12]; rsp_ppn = v ^ XKEY;
        rsp_perm = {~v[8], ~v[9], ~v[10]}; rsp_dirty = v[11];
        walk_cnt++;
        @(negedge clk);
        rsp_valid = 0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R2", "unexpected response", "none");
      end else begin
        exp_t e;
        int w;
        e = exp_q.pop_front();
        w = walk_cnt - walk_base;
        walk_base = walk_cnt;
        check(resp_kind == e.kind, e.tag, $sformatf("kind %0d", resp_kind), $sformatf("kind %0d", e.kind));
        check(resp_ppn == e.ppn, e.tag, $sformatf("ppn %h", resp_ppn), $sformatf("ppn %h", e.ppn));
        check(resp_dirty == e.dirty, e.tag, $sformatf("dirty %0b", resp_dirty), $sformatf("dirty %0b", e.dirty));
        check(w == e.walks, e.tag, $sformatf("%0d walks", w), $sformatf("%0d walks", e.walks));
      end
    end
  end

  task automatic push(input logic [1:0] k, input logic [19:0] p, input logic d, input int w, input string tag);
    exp_t e;
    e.kind = k; e.ppn = p; e.dirty = d; e.walks = w; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drive(input logic [19:0] v, input logic [1:0] a);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_vpn = v; req_acc = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic acc_ok(input logic [19:0] v, input logic [1:0] a, input logic d, input int w, input string tag);
    push(2'd0, v ^ XKEY, d, w, tag);
    drive(v, a);
    drain();
  endtask

  task automatic acc_fault(input logic [19:0] v, input logic [1:0] a, input logic [1:0] k, input int w, input string tag);
    push(k, '0, 1'b0, w, tag);
    drive(v, a);
    drain();
  endtask

  task automatic flush;
    @(negedge clk);
    ptbr_we = 1;
    #1 check(!req_ready, "R11", $sformatf("ready %0b", req_ready), "ready 0 during flush");
    @(negedge clk);
    ptbr_we = 0;
  endtask

  task automatic inval(input logic [19:0] v);
    @(negedge clk);
    inval_valid = 1; inval_vpn = v;
    @(negedge clk);
    inval_valid = 0;
  endtask

  // R9: flush (sel=0) or unrelated invalidate (sel=1) lands mid-walk
  task automatic abort_case(input logic [19:0] v, input bit sel);
    push(2'd0, v ^ XKEY, 1'b0, 2, "R9");
    drive(v, 2'd0);
    while (!walk_req) @(negedge clk);
    check(!req_ready, "R11", $sformatf("ready %0b", req_ready), "ready 0 during walk");
    if (sel) begin inval_valid = 1; inval_vpn = 20'h77777; end
    else ptbr_we = 1;
    @(negedge clk);
    ptbr_we = 0; inval_valid = 0;
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !resp_valid && !walk_req, "R1",
          $sformatf("rdy %0b rv %0b wr %0b", req_ready, resp_valid, walk_req), "rdy 1 rv 0 wr 0");
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !resp_valid && !walk_req, "R1",
          $sformatf("rdy %0b rv %0b wr %0b", req_ready, resp_valid, walk_req), "rdy 1 rv 0 wr 0");

    // R3 / R2
    acc_ok(20'h00010, 2'd0, 0, 1, "R3");
    acc_ok(20'h00010, 2'd0, 0, 0, "R2");
    // R6
    acc_ok(20'h00010, 2'd1, 0, 0, "R6");
    acc_ok(20'h00010, 2'd1, 1, 0, "R6");
    acc_ok(20'h00010, 2'd0, 1, 0, "R6");
    // R5
    acc_fault(20'h00400, 2'd2, 2'd1, 1, "R5");
    acc_fault(20'h00200, 2'd1, 2'd1, 1, "R5");
    acc_ok(20'h00200, 2'd0, 0, 0, "R5");
    acc_fault(20'h00100, 2'd0, 2'd1, 1, "R5");
    acc_ok(20'h00100, 2'd2, 0, 0, "R5");
    // R4
    acc_fault(20'h01000, 2'd0, 2'd2, 1, "R4");
    acc_fault(20'h01000, 2'd0, 2'd2, 1, "R4");
    // R7
    flush();
    acc_ok(20'h00010, 2'd0, 0, 1, "R7");
    acc_ok(20'h00200, 2'd0, 0, 1, "R7");
    // R8
    acc_ok(20'h00020, 2'd0, 0, 1, "R8");
    acc_ok(20'h00030, 2'd0, 0, 1, "R8");
    inval(20'h00020);
    acc_ok(20'h00030, 2'd0, 0, 0, "R8");
    acc_ok(20'h00010, 2'd0, 0, 0, "R8");
    acc_ok(20'h00020, 2'd0, 0, 1, "R8");
    // R9
    abort_case(20'h00040, 0);
    acc_ok(20'h00040, 2'd0, 0, 0, "R9");
    abort_case(20'h00050, 1);
    // R10
    flush();
    for (int i = 0; i < 64; i++) acc_ok(20'h02000 + 20'(i), 2'd0, 0, 1, "R10");
    acc_ok(20'h02000, 2'd0, 0, 0, "R10");
    acc_ok(20'h04000, 2'd0, 0, 1, "R10");
    acc_ok(20'h02000, 2'd0, 0, 0, "R10");
    acc_ok(20'h02001, 2'd0, 0, 1, "R10");
    acc_ok(20'h02003, 2'd0, 0, 0, "R10");
    inval(20'h02010);
    acc_ok(20'h04001, 2'd0, 0, 1, "R10");
    acc_ok(20'h02004, 2'd0, 0, 0, "R10");
    acc_ok(20'h02010, 2'd0, 0, 1, "R10");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule